// File: doc/BRIEF.md
# ATM Transmit Cell Header Check and Payload Scrambler

This block is the outbound cell stage for 53-octet ATM cells. Cells arrive one octet per valid cycle, and a start marker flags the first header octet. The block forms the header check octet from header octets 1 to 4 and places it in octet 5. On the way it can fold in a fixed coset pattern and a software-supplied error pattern. It can also scramble payload octets 6 to 53 with a self-synchronizing scrambler whose lag is 43 bits. Every octet leaves exactly one clock after it enters. Valid and start markers are delayed by the same clock, so the block can sit in a byte stream without any change to the stages around it.

Two byte-wide registers, reached through a simple write/read port, set the behaviour. The control register is at address 0. Bit 7 enables scrambling, bit 6 enables the coset and bit 5 enables header check insertion. Bits 4..0 are held for software and have no effect here. The error-pattern register is at address 1. A test setup writes a non-zero pattern to send cells with deliberately wrong header checks to far-end equipment.

Top module: `atm_txcp`

## Requirements
- R1: After reset the control register reads 8'h72 (scrambling off, coset on, header check insertion on), the error-pattern register reads 8'h00, and out_valid is low.
- R2: out_valid, out_soc and out_data repeat in_valid, (in_valid and in_soc) and the processed in_data with a latency of exactly one clock.
- R3: With control bit 5 = 1, octet 5 is replaced by the CRC-8 of octets 1 to 4. The generator is x^8+x^2+x+1, the register starts at zero, and bits are taken MSB first. The header 00 00 00 01 gives 8'h07 before the coset.
- R4: With control bit 6 = 1, the value 8'h55 is XORed into the inserted check octet. The header 00 00 00 01 then gives 8'h52. With bit 6 = 0 the coset is not applied.
- R5: The error-pattern register (address 1) is XORed into the inserted check octet after the coset. With pattern 8'h00 no error is injected.
- R6: With control bit 5 = 0, octet 5 leaves unchanged, whatever the coset bit and the error pattern hold.
- R7: Header octets 1 to 4 always leave unchanged.
- R8: With control bit 7 = 1, each payload bit (octets 6 to 53, MSB first) leaves as the input bit XOR the output bit sent 43 scrambled bit-times earlier. The history is all zero after reset.
- R9: The scrambler history carries across cells. It advances only on scrambled payload octets, so header octets, idle cycles and octets sent with scrambling off leave it as it was.
- R10: With control bit 7 = 0, payload octets leave unchanged.
- R11: A valid octet with in_soc = 1 is always octet 1. After octet 53 the next valid octet is octet 1 even without in_soc. A cut-short cell is abandoned when a new start arrives.
- R12: A write with reg_wr = 1 loads the register at reg_addr. reg_rdata shows the register at reg_addr one clock later, and 0 for unmapped addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address (0 control, 1 error pattern) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data for reg_addr |
| in_valid | input | 1 | Input octet valid |
| in_soc | input | 1 | Input octet is the first of a cell |
| in_data | input | 8 | Input octet |
| out_valid | output | 1 | Output octet valid |
| out_soc | output | 1 | Output octet is the first of a cell |
| out_data | output | 8 | Processed output octet |

## Verification
The bench uses the default parameters: 53-octet cells, a 4-octet header and a 43-bit scrambler lag. With these values the lag is more than five octets, so one cell's last payload bits feed the next cell's first payload bits. This brings the carry-over across the header, across idle gaps and across a stretch with scrambling off within reach of back-to-back cells. The known idle-header check value, 8'h52, pins down the CRC and coset ordering exactly.

// File: rtl/atm_txcp_pkg.sv
package atm_txcp_pkg;

  localparam int OCT_W     = 8;
  localparam int CB_SCR    = 7;
  localparam int CB_COSET  = 6;
  localparam int CB_HECINS = 5;

  // One octet through a CRC-8 shift register, MSB first.
  function automatic logic [OCT_W-1:0] crc8_step(
    input logic [OCT_W-1:0] crc_in,
    input logic [OCT_W-1:0] d,
    input logic [OCT_W-1:0] poly
  );
    logic [OCT_W-1:0] c;
    logic             fb;
    c = crc_in;
    for (int i = OCT_W - 1; i >= 0; i--) begin
      fb = c[OCT_W-1] ^ d[i];
      c  = {c[OCT_W-2:0], 1'b0};
      if (fb) c = c ^ poly;
    end
    return c;
  endfunction

endpackage

// File: rtl/atm_txcp_regs.sv
module atm_txcp_regs
  import atm_txcp_pkg::*;
#(
  parameter int             ADDR_W     = 4,
  parameter int             CTRL_ADDR  = 0,
  parameter int             MASK_ADDR  = 1,
  parameter logic [OCT_W-1:0] CTRL_RESET = 8'h72
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [OCT_W-1:0]  reg_wdata,
  output logic [OCT_W-1:0]  reg_rdata,
  output logic              scr_en,
  output logic              coset_en,
  output logic              hec_ins_en,
  output logic [OCT_W-1:0]  err_mask
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(MASK_ADDR);

  logic [OCT_W-1:0] ctrl_q;
  logic [OCT_W-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= CTRL_RESET;
      mask_q    <= '0;
      reg_rdata <= '0;
    end else begin
      if (reg_wr && reg_addr == A_CTRL) ctrl_q <= reg_wdata;
      if (reg_wr && reg_addr == A_MASK) mask_q <= reg_wdata;
      if (reg_addr == A_CTRL)      reg_rdata <= ctrl_q;
      else if (reg_addr == A_MASK) reg_rdata <= mask_q;
      else                         reg_rdata <= '0;
    end
  end

  assign scr_en     = ctrl_q[CB_SCR];
  assign coset_en   = ctrl_q[CB_COSET];
  assign hec_ins_en = ctrl_q[CB_HECINS];
  assign err_mask   = mask_q;

endmodule

// File: rtl/atm_txcp_pos.sv
module atm_txcp_pos #(
  parameter int CELL_LEN = 53,
  localparam int POS_W   = $clog2(CELL_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_soc,
  output logic [POS_W-1:0] pos
);

  localparam logic [POS_W-1:0] LAST = POS_W'(CELL_LEN - 1);

  logic [POS_W-1:0] cnt_q;

  // A start marker forces octet index zero; otherwise use the running count.
  assign pos = in_soc ? '0 : cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (in_valid) begin
      cnt_q <= (pos == LAST) ? '0 : pos + 1'b1;
    end
  end

endmodule

// File: rtl/atm_txcp_hec.sv
module atm_txcp_hec
  import atm_txcp_pkg::*;
#(
  parameter int               CELL_LEN  = 53,
  parameter int               HDR_LEN   = 4,
  parameter logic [OCT_W-1:0] HEC_POLY  = 8'h07,
  parameter logic [OCT_W-1:0] COSET_VAL = 8'h55,
  localparam int              POS_W     = $clog2(CELL_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [POS_W-1:0] pos,
  input  logic [OCT_W-1:0] in_data,
  input  logic             coset_en,
  input  logic [OCT_W-1:0] err_mask,
  output logic [OCT_W-1:0] hec_byte
);

  localparam logic [POS_W-1:0] HDR_END = POS_W'(HDR_LEN);

  logic [OCT_W-1:0] crc_q;
  logic [OCT_W-1:0] crc_seed;

  assign crc_seed = (pos == '0) ? '0 : crc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      crc_q <= '0;
    end else if (in_valid && pos < HDR_END) begin
      crc_q <= crc8_step(crc_seed, in_data, HEC_POLY);
    end
  end

  // Coset first, error pattern second.
  assign hec_byte = (crc_q ^ (coset_en ? COSET_VAL : '0)) ^ err_mask;

endmodule

// File: rtl/atm_txcp_scr.sv
module atm_txcp_scr
  import atm_txcp_pkg::*;
#(
  parameter int SCR_LAG = 43
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic [OCT_W-1:0] din,
  output logic [OCT_W-1:0] dout
);

  logic [SCR_LAG-1:0] hist_q;
  logic [SCR_LAG-1:0] hist_nxt;

  generate
    if (SCR_LAG > OCT_W) begin : g_wide
      // Every tap lies in stored history: one XOR level per output bit.
      always_comb begin
        logic [SCR_LAG-1:0] h;
        logic               o;
        h    = hist_q;
        dout = '0;
        for (int i = OCT_W - 1; i >= 0; i--) begin
          o       = din[i] ^ h[SCR_LAG-1];
          dout[i] = o;
          h       = {h[SCR_LAG-2:0], o};
        end
        hist_nxt = h;
      end
    end else begin : g_narrow
      // Short lag: taps reach into bits of the same octet.
      always_comb begin
        logic [SCR_LAG+OCT_W-1:0] h;
        logic                     o;
        h = {{OCT_W{1'b0}}, hist_q};
        dout = '0;
        for (int i = OCT_W - 1; i >= 0; i--) begin
          o       = din[i] ^ h[SCR_LAG-1];
          dout[i] = o;
          h       = {h[SCR_LAG+OCT_W-2:0], o};
        end
        hist_nxt = h[SCR_LAG-1:0];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)      hist_q <= '0;
    else if (adv) hist_q <= hist_nxt;
  end

endmodule

// File: rtl/atm_txcp.sv
module atm_txcp
  import atm_txcp_pkg::*;
#(
  parameter int               CELL_LEN   = 53,
  parameter int               HDR_LEN    = 4,
  parameter int               SCR_LAG    = 43,
  parameter int               ADDR_W     = 4,
  parameter int               CTRL_ADDR  = 0,
  parameter int               MASK_ADDR  = 1,
  parameter logic [OCT_W-1:0] HEC_POLY   = 8'h07,
  parameter logic [OCT_W-1:0] COSET_VAL  = 8'h55,
  parameter logic [OCT_W-1:0] CTRL_RESET = 8'h72
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [OCT_W-1:0]  reg_wdata,
  output logic [OCT_W-1:0]  reg_rdata,
  input  logic              in_valid,
  input  logic              in_soc,
  input  logic [OCT_W-1:0]  in_data,
  output logic              out_valid,
  output logic              out_soc,
  output logic [OCT_W-1:0]  out_data
);

  localparam int               POS_W   = $clog2(CELL_LEN);
  localparam logic [POS_W-1:0] HEC_IDX = POS_W'(HDR_LEN);

  logic             scr_en;
  logic             coset_en;
  logic             hec_ins_en;
  logic [OCT_W-1:0] err_mask;
  logic [POS_W-1:0] pos;
  logic [OCT_W-1:0] hec_byte;
  logic [OCT_W-1:0] scr_out;
  logic             is_hec;
  logic             is_pay;
  logic             scr_adv;
  logic [OCT_W-1:0] data_nxt;

  atm_txcp_regs #(
    .ADDR_W    (ADDR_W),
    .CTRL_ADDR (CTRL_ADDR),
    .MASK_ADDR (MASK_ADDR),
    .CTRL_RESET(CTRL_RESET)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .scr_en    (scr_en),
    .coset_en  (coset_en),
    .hec_ins_en(hec_ins_en),
    .err_mask  (err_mask)
  );

  atm_txcp_pos #(
    .CELL_LEN(CELL_LEN)
  ) u_pos (
    .clk     (clk),
    .rst     (rst),
    .in_valid(in_valid),
    .in_soc  (in_soc),
    .pos     (pos)
  );

  atm_txcp_hec #(
    .CELL_LEN (CELL_LEN),
    .HDR_LEN  (HDR_LEN),
    .HEC_POLY (HEC_POLY),
    .COSET_VAL(COSET_VAL)
  ) u_hec (
    .clk     (clk),
    .rst     (rst),
    .in_valid(in_valid),
    .pos     (pos),
    .in_data (in_data),
    .coset_en(coset_en),
    .err_mask(err_mask),
    .hec_byte(hec_byte)
  );

  atm_txcp_scr #(
    .SCR_LAG(SCR_LAG)
  ) u_scr (
    .clk (clk),
    .rst (rst),
    .adv (scr_adv),
    .din (in_data),
    .dout(scr_out)
  );

  assign is_hec  = (pos == HEC_IDX);
  assign is_pay  = (pos > HEC_IDX);
  assign scr_adv = in_valid && is_pay && scr_en;

  always_comb begin
    if (is_hec && hec_ins_en)  data_nxt = hec_byte;
    else if (is_pay && scr_en) data_nxt = scr_out;
    else                       data_nxt = in_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_soc   <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      out_soc   <= in_valid && in_soc;
      out_data  <= data_nxt;
    end
  end

endmodule

// File: rtl/atm_txcp_chk.sv
module atm_txcp_chk #(
  parameter int CELL_LEN = 53,
  parameter int HDR_LEN  = 4,
  localparam int POS_W   = $clog2(CELL_LEN)
) (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       in_soc,
  input logic [7:0] in_data,
  input logic       out_valid,
  input logic       out_soc,
  input logic [7:0] out_data,
  input logic       hec_ins_en,
  input logic       scr_en
);

  logic [POS_W-1:0] c_cnt;
  logic [POS_W-1:0] c_pos;

  assign c_pos = in_soc ? '0 : c_cnt;

  always_ff @(posedge clk) begin
    if (rst) c_cnt <= '0;
    else if (in_valid)
      c_cnt <= (c_pos == POS_W'(CELL_LEN - 1)) ? '0 : c_pos + 1'b1;
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (out_valid == $past(in_valid))); // R2

  AST_SOC_LATENCY: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (out_soc == ($past(in_valid) && $past(in_soc)))); // R2

  AST_HDR_PASS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid) && $past(c_pos) < POS_W'(HDR_LEN))
      |-> (out_data == $past(in_data))); // R7

  AST_NOINS_PASS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid) && $past(c_pos) == POS_W'(HDR_LEN) && !$past(hec_ins_en))
      |-> (out_data == $past(in_data))); // R6

  AST_SCROFF_PASS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid) && $past(c_pos) > POS_W'(HDR_LEN) && !$past(scr_en))
      |-> (out_data == $past(in_data))); // R10

endmodule

bind atm_txcp atm_txcp_chk #(
  .CELL_LEN(CELL_LEN),
  .HDR_LEN (HDR_LEN)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_soc    (in_soc),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_soc   (out_soc),
  .out_data  (out_data),
  .hec_ins_en(hec_ins_en),
  .scr_en    (scr_en)
);

// File: tb/atm_txcp_tb.sv
`timescale 1ns/1ps
module atm_txcp_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       in_valid = 1'b0;
  logic       in_soc = 1'b0;
  logic [7:0] in_data = '0;
  logic       out_valid;
  logic       out_soc;
  logic [7:0] out_data;

  always #2.5 clk = ~clk;

  atm_txcp u_dut (
    .clk(clk), .rst(rst),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .in_valid(in_valid), .in_soc(in_soc), .in_data(in_data),
    .out_valid(out_valid), .out_soc(out_soc), .out_data(out_data)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [7:0] tb_ctrl = 8'h72;
  logic [7:0] tb_mask = 8'h00;
  logic       m_buf [43];
  int         m_ptr = 0;

  logic [7:0] cap_d [64];
  logic       cap_s [64];
  int         cap_n = 0;

  typedef struct packed {
    logic [31:0] hdr;
    logic [7:0]  oct5;
    logic [7:0]  ctrl;
    logic [7:0]  mask;
    logic [7:0]  seed;
    logic        gaps;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{32'h00000001, 8'h00, 8'h72, 8'h00, 8'h11, 1'b0}, // R3 R4 idle header
    '{32'h12345678, 8'h9A, 8'h32, 8'h00, 8'h22, 1'b0}, // R3 coset off
    '{32'hA5A5F00F, 8'h00, 8'h72, 8'h81, 8'h33, 1'b0}, // R5 error pattern
    '{32'hDEADBEEF, 8'h3C, 8'h52, 8'hFF, 8'h44, 1'b0}, // R6 insertion off
    '{32'h0F0F0F0F, 8'h00, 8'hF2, 8'h00, 8'h55, 1'b0}, // R8 scrambling on
    '{32'hFFFFFFFF, 8'h00, 8'hF2, 8'h00, 8'h66, 1'b0}, // R9 carry across cells
    '{32'h01020304, 8'h00, 8'hF2, 8'h00, 8'h77, 1'b1}, // R9 idle gaps
    '{32'h80000000, 8'h00, 8'h72, 8'h00, 8'h88, 1'b0}, // R10 scrambling off
    '{32'h00FF00FF, 8'h00, 8'hF2, 8'h00, 8'h99, 1'b0}  // R9 history held while off
  };
  localparam string VTAG [NV] = '{"R3/R4", "R3", "R5", "R6", "R8", "R9", "R9", "R10", "R9"};

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (cap_n < 64) begin
        cap_d[cap_n] = out_data;
        cap_s[cap_n] = out_soc;
      end
      cap_n++;
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Check octet by long division of header*x^8 by x^8+x^2+x+1.
  function automatic logic [7:0] crc_ref(input logic [31:0] hdr);
    logic [39:0] r;
    r = {hdr, 8'h00};
    for (int b = 39; b >= 8; b--)
      if (r[b]) r = r ^ (40'h107 << (b - 8));
    return r[7:0];
  endfunction

  // Circular history of past scrambled bits; the oldest sits at m_ptr.
  task automatic scr_model(input logic [7:0] d, output logic [7:0] q);
    for (int i = 7; i >= 0; i--) begin
      q[i] = d[i] ^ m_buf[m_ptr];
      m_buf[m_ptr] = q[i];
      m_ptr = (m_ptr == 42) ? 0 : m_ptr + 1;
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    if (a == 4'd0) tb_ctrl = d;
    if (a == 4'd1) tb_mask = d;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic run_cell(input logic [31:0] hdr, input logic [7:0] oct5, input logic [7:0] seed,
                          input bit gaps, input bit mark_soc, input string tag);
    logic [7:0] src [53];
    logic [7:0] expv [53];
    int bad;
    for (int k = 0; k < 53; k++) begin
      if (k < 4)       src[k] = hdr[31 - 8*k -: 8];
      else if (k == 4) src[k] = oct5;
      else             src[k] = seed + 8'(k * 37);
      if (k < 4)       expv[k] = src[k];
      else if (k == 4) expv[k] = tb_ctrl[5] ? (crc_ref(hdr) ^ (tb_ctrl[6] ? 8'h55 : 8'h00) ^ tb_mask) : src[k];
      else if (tb_ctrl[7]) scr_model(src[k], expv[k]);
      else             expv[k] = src[k];
    end
    cap_n = 0;
    for (int k = 0; k < 53; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_soc = mark_soc && (k == 0); in_data = src[k];
      if (gaps && (k % 7 == 6)) begin
        @(negedge clk);
        in_valid = 1'b0; in_soc = 1'b0;
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_soc = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(cap_n == 53, tag, "octet count", 32'(cap_n), 32'd53);
    bad = -1;
    for (int k = 0; k < 53; k++)
      if (bad < 0 && cap_d[k] !== expv[k]) bad = k;
    if (bad < 0) check(1'b1, tag, "cell data", 0, 0);
    else check(1'b0, tag, $sformatf("octet %0d", bad + 1), 32'(cap_d[bad]), 32'(expv[bad]));
    bad = -1;
    for (int k = 0; k < 53; k++)
      if (bad < 0 && cap_s[k] !== (mark_soc && k == 0)) bad = k;
    check(bad < 0, tag, "R2 start marker position", 32'(bad), 32'hFFFFFFFF);
  endtask

  initial begin
    logic [7:0] rv;
    for (int i = 0; i < 43; i++) m_buf[i] = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid after reset", 32'(out_valid), 0);
    rd_reg(4'd0, rv);
    check(rv == 8'h72, "R1", "control reset value", 32'(rv), 32'h72);
    rd_reg(4'd1, rv);
    check(rv == 8'h00, "R1", "error pattern reset value", 32'(rv), 0);
    rd_reg(4'd7, rv);
    check(rv == 8'h00, "R12", "unmapped address reads zero", 32'(rv), 0);

    // R2: one-clock latency of a single octet
    @(negedge clk);
    in_valid = 1'b1; in_soc = 1'b1; in_data = 8'hC3;
    @(negedge clk);
    in_valid = 1'b0; in_soc = 1'b0;
    check(out_valid && out_soc && out_data == 8'hC3, "R2", "octet after one clock",
          {22'd0, out_valid, out_soc, out_data}, {22'd0, 2'b11, 8'hC3});
    @(negedge clk);
    check(out_valid == 1'b0, "R2", "valid drops one clock after input", 32'(out_valid), 0);
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      wr_reg(4'd0, VECS[v].ctrl);
      wr_reg(4'd1, VECS[v].mask);
      run_cell(VECS[v].hdr, VECS[v].oct5, VECS[v].seed, VECS[v].gaps, 1'b1, VTAG[v]);
      if (v == 0)
        check(cap_d[4] == 8'h52, "R4", "idle header check octet", 32'(cap_d[4]), 32'h52);
      if (v == 2) begin
        rd_reg(4'd1, rv);
        check(rv == 8'h81, "R12", "error pattern readback", 32'(rv), 32'h81);
      end
    end

    // R11: abandoned partial cell, then a fresh start
    wr_reg(4'd0, 8'h72);
    wr_reg(4'd1, 8'h00);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_soc = (k == 0); in_data = 8'hE0 + 8'(k);
    end
    @(negedge clk);
    in_valid = 1'b0; in_soc = 1'b0;
    @(negedge clk);
    @(negedge clk);
    run_cell(32'h00000001, 8'h00, 8'hAB, 1'b0, 1'b1, "R11");
    check(cap_d[4] == 8'h52, "R11", "check octet after restart", 32'(cap_d[4]), 32'h52);

    // R11: wrap after octet 53 without a start marker, scrambling on
    wr_reg(4'd0, 8'hF2);
    run_cell(32'h11223344, 8'h00, 8'h05, 1'b0, 1'b1, "R11");
    run_cell(32'h55667788, 8'h00, 8'h06, 1'b0, 1'b0, "R11");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule